// File: doc/BRIEF.md
# Masked Chip-Select Decoder

This block turns a 32-bit bus address into six active-low chip-select lines. Each select line has a programmable base (the upper 16 address bits), a per-bit mask that turns chosen base bits into don't-cares, a write-protect flag and an enable flag. Because any mask bits may be set, one select line can cover several separate 64 KB blocks. A region covers 2^(16 + number of set mask bits) bytes in total.

After reset every select line is disabled and select 0 acts as a boot select: it answers every access until its own enable flag is set. From then on all six lines decode against their programmed settings. When more than one enabled region matches, the lowest-numbered one wins. A write whose winning region is write-protected drives no select and raises a one-cycle bus-error pulse. Settings are written and read through a small indexed register port.

Top module: `csel_decoder`

## Requirements
- R1: After a synchronous reset, every enable flag, base, mask and protect bit is 0, all `cs_n` bits are 1, `bus_err` is 0, and every register reads back as 0.
- R2: While the enable flag of select 0 is 0, each cycle with `bus_start`=1 asserts `cs_n[0]` alone, for reads and writes at any address, whatever the protect bits hold, and `bus_err` stays 0.
- R3: Once select 0 is enabled, select i matches when `((bus_addr[31:16] ^ base_i) & ~mask_i) == 0`. A mask bit of 1 is a don't-care, so base 0x0000 with mask 0x0008 matches both 0x0000_xxxx and 0x0008_xxxx.
- R4: A select whose enable flag is 0 never asserts, even when its base matches.
- R5: When several enabled regions match, only the lowest-numbered one can assert.
- R6: When the winning region has its protect bit set and `bus_rd`=0, no select asserts and `bus_err` is 1 in that same cycle. A read to the same region asserts its select normally.
- R7: `cs_n` is registered. It shows the decode of the cycle with `bus_start`=1 one clock later, and it is all ones after a cycle with `bus_start`=0. At most one bit is ever 0.
- R8: Register index `reg_idx` = 2*i + k addresses select i (i = 0 to 5). For k=0 (base), bits 31:16 hold the base. For k=1 (mask), bits 31:16 hold the mask, bit 8 holds write-protect and bit 0 holds enable. All other bits read 0 and ignore writes. Indices 12 to 15 read 0 and ignore writes. `reg_rdata` shows the register selected by `reg_idx` one clock later. A written value takes effect from the next cycle.
- R9: `bus_err` is 1 only in a cycle with `bus_start`=1 and `bus_rd`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Bus address of the access |
| bus_rd | input | 1 | 1 = read access, 0 = write access |
| bus_start | input | 1 | Transfer-start strobe; the access is decoded in this cycle |
| reg_wr | input | 1 | Register write enable |
| reg_idx | input | 4 | Register index, 2*select + kind |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the register at `reg_idx` |
| cs_n | output | 6 | Active-low chip selects, registered |
| bus_err | output | 1 | One-cycle bus-error pulse for a protected write |

## Verification
The hardest situation to reach is a single address that falls inside several enabled regions, one of which is protected. It must be shown that a protected lower-numbered winner suppresses the higher-numbered match instead of handing the access to it. The stimulus builds this up step by step. It first programs registers while select 0 is still in boot mode, which also proves those registers have no effect there. It then enables a masked, protected region, adds a second region that overlaps it, and sends both reads and writes at the shared address. A final reset mid-run checks the return to boot decoding.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int TAG_W   = 16;
  localparam int WP_BIT  = 8;
  localparam int VAL_BIT = 0;

  typedef struct packed {
    logic [TAG_W-1:0] base;
    logic [TAG_W-1:0] mask;
    logic             wp;
    logic             valid;
  } csel_cfg_t;
endpackage

// File: rtl/csel_regfile.sv
module csel_regfile
  import csel_pkg::*;
#(
  parameter int NUM_SEL = 6,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          idx,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  output csel_cfg_t [NUM_SEL-1:0]   cfg
);
  csel_cfg_t [NUM_SEL-1:0] cfg_q;
  logic [DATA_W-1:0]       rd_next;
  logic [NUM_SEL-1:0]      valid_vec;
  logic                    unused_wdata_bits;

  assign unused_wdata_bits = ^{wdata[DATA_W-TAG_W-1:WP_BIT+1], wdata[WP_BIT-1:VAL_BIT+1]};

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[i] <= '0;
      end else if (wr_en) begin
        if (idx == IDX_W'(2*i)) begin
          cfg_q[i].base <= wdata[DATA_W-1 -: TAG_W];
        end else if (idx == IDX_W'(2*i+1)) begin
          cfg_q[i].mask  <= wdata[DATA_W-1 -: TAG_W];
          cfg_q[i].wp    <= wdata[WP_BIT];
          cfg_q[i].valid <= wdata[VAL_BIT];
        end
      end
    end
    assign valid_vec[i] = cfg_q[i].valid;
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_SEL; i++) begin
      if (idx == IDX_W'(2*i)) begin
        rd_next[DATA_W-1 -: TAG_W] = cfg_q[i].base;
      end else if (idx == IDX_W'(2*i+1)) begin
        rd_next[DATA_W-1 -: TAG_W] = cfg_q[i].mask;
        rd_next[WP_BIT]            = cfg_q[i].wp;
        rd_next[VAL_BIT]           = cfg_q[i].valid;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  assign cfg = cfg_q;

  // R1
  valid_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (valid_vec == '0));
endmodule

// File: rtl/csel_match.sv
module csel_match
  import csel_pkg::*;
#(
  parameter int NUM_SEL = 6
) (
  input  logic [TAG_W-1:0]        tag,
  input  csel_cfg_t [NUM_SEL-1:0] cfg,
  output logic [NUM_SEL-1:0]      hit
);
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_cmp
    logic [TAG_W-1:0] diff;
    assign diff   = (tag ^ cfg[i].base) & ~cfg[i].mask;
    assign hit[i] = cfg[i].valid && (diff == '0);
  end
endmodule

// File: rtl/csel_arbiter.sv
module csel_arbiter
  import csel_pkg::*;
#(
  parameter int NUM_SEL = 6
) (
  input  logic [NUM_SEL-1:0]      hit,
  input  csel_cfg_t [NUM_SEL-1:0] cfg,
  input  logic                    start,
  input  logic                    rd,
  output logic [NUM_SEL-1:0]      sel,
  output logic                    err
);
  logic [NUM_SEL-1:0] grant;
  logic [NUM_SEL-1:0] wp_vec;
  logic               boot_mode;
  logic               blocked;

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_wp
    assign wp_vec[i] = cfg[i].wp;
  end

  assign boot_mode = !cfg[0].valid;
  assign grant     = hit & (~hit + NUM_SEL'(1));
  assign blocked   = (|(grant & wp_vec)) && !rd;

  always_comb begin
    sel = '0;
    err = 1'b0;
    if (start) begin
      if (boot_mode) begin
        sel[0] = 1'b1;
      end else if (blocked) begin
        err = 1'b1;
      end else begin
        sel = grant;
      end
    end
  end
endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
  import csel_pkg::*;
#(
  parameter int NUM_SEL = 6,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(2*NUM_SEL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_rd,
  input  logic               bus_start,
  input  logic               reg_wr,
  input  logic [IDX_W-1:0]   reg_idx,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [NUM_SEL-1:0] cs_n,
  output logic               bus_err
);
  csel_cfg_t [NUM_SEL-1:0] cfg;
  logic [NUM_SEL-1:0]      hit;
  logic [NUM_SEL-1:0]      sel;
  logic                    unused_addr_low;

  assign unused_addr_low = ^bus_addr[ADDR_W-TAG_W-1:0];

  csel_regfile #(.NUM_SEL(NUM_SEL), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .idx(reg_idx),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg)
  );

  csel_match #(.NUM_SEL(NUM_SEL)) u_match (
    .tag(bus_addr[ADDR_W-1 -: TAG_W]), .cfg(cfg), .hit(hit)
  );

  csel_arbiter #(.NUM_SEL(NUM_SEL)) u_arb (
    .hit(hit), .cfg(cfg), .start(bus_start), .rd(bus_rd),
    .sel(sel), .err(bus_err)
  );

  always_ff @(posedge clk) begin
    if (rst) cs_n <= '1;
    else     cs_n <= ~sel;
  end

  // R7
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_start |=> (cs_n == '1));
  // R7
  single_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
  // R9
  err_write_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (bus_start && !bus_rd));
  // R6
  err_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |=> (cs_n == '1));
  // R2
  boot_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_start && !cfg[0].valid) |=> (cs_n == {{(NUM_SEL-1){1'b1}}, 1'b0}));
endmodule

// File: tb/sim_csel_decoder.sv
module sim_csel_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] bus_addr;
  logic        bus_rd;
  logic        bus_start;
  logic        reg_wr;
  logic [3:0]  reg_idx;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [5:0]  cs_n;
  logic        bus_err;

  int checks = 0;
  int errors = 0;

  logic [5:0]  exp_q[$];
  string       tag_q[$];

  logic [15:0] m_base[6];
  logic [15:0] m_mask[6];
  logic        m_wp[6];
  logic        m_val[6];

  always #(CLK_PERIOD/2) clk = ~clk;

  csel_decoder u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_start(bus_start), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cs_n(cs_n), .bus_err(bus_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int i = 0; i < 6; i++) begin
      m_base[i] = '0; m_mask[i] = '0; m_wp[i] = 1'b0; m_val[i] = 1'b0;
    end
  endfunction

  function automatic void model_write(input logic [3:0] ix, input logic [31:0] wd);
    if (ix < 4'd12) begin
      if (ix[0] == 1'b0) m_base[ix >> 1] = wd[31:16];
      else begin
        m_mask[ix >> 1] = wd[31:16];
        m_wp[ix >> 1]   = wd[8];
        m_val[ix >> 1]  = wd[0];
      end
    end
  endfunction

  function automatic logic [31:0] model_read(input logic [3:0] ix);
    logic [31:0] v = '0;
    if (ix < 4'd12) begin
      if (ix[0] == 1'b0) v[31:16] = m_base[ix >> 1];
      else begin
        v[31:16] = m_mask[ix >> 1];
        v[8]     = m_wp[ix >> 1];
        v[0]     = m_val[ix >> 1];
      end
    end
    return v;
  endfunction

  function automatic void model_expect(input logic st, input logic rd, input logic [31:0] a,
                                       output logic [5:0] cs, output logic err);
    logic found = 1'b0;
    cs = '1; err = 1'b0;
    if (st) begin
      if (!m_val[0]) cs = 6'b111110;
      else begin
        for (int i = 0; i < 6; i++) begin
          if (!found && m_val[i] && (((a[31:16] ^ m_base[i]) & ~m_mask[i]) == 16'h0)) begin
            found = 1'b1;
            if (m_wp[i] && !rd) err = 1'b1;
            else cs[i] = 1'b0;
          end
        end
      end
    end
  endfunction

  task automatic tick(input logic st, input logic rd, input logic [31:0] a,
                      input logic w, input logic [3:0] ix, input logic [31:0] wd,
                      input string tag);
    logic [5:0] ecs;
    logic       eerr;
    @(negedge clk);
    bus_start = st; bus_rd = rd; bus_addr = a;
    reg_wr = w; reg_idx = ix; reg_wdata = wd;
    model_expect(st, rd, a, ecs, eerr);
    #1;
    check({tag, " bus_err"}, {31'b0, bus_err}, {31'b0, eerr});
    exp_q.push_back(ecs);
    tag_q.push_back(tag);
    if (w) model_write(ix, wd);
  endtask

  task automatic access(input logic rd, input logic [31:0] a, input string tag);
    tick(1'b1, rd, a, 1'b0, 4'd0, 32'h0, tag);
  endtask

  task automatic wreg(input logic [3:0] ix, input logic [31:0] wd);
    tick(1'b0, 1'b1, 32'h0, 1'b1, ix, wd, "R8 write");
  endtask

  task automatic rreg(input logic [3:0] ix, input string tag);
    tick(1'b0, 1'b1, 32'h0, 1'b0, ix, 32'h0, tag);
    @(negedge clk);
    check({tag, " rdata"}, reg_rdata, model_read(ix));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_start = 1'b0; reg_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
    #1;
    check("R1 cs_n", {26'b0, cs_n}, {26'b0, 6'h3F});
    check("R1 bus_err", {31'b0, bus_err}, 32'h0);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      if (exp_q.size() > 0) begin
        logic [5:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        #1;
        check({t, " cs_n"}, {26'b0, cs_n}, {26'b0, e});
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_rd = 1'b1; bus_start = 1'b0;
    reg_wr = 1'b0; reg_idx = '0; reg_wdata = '0;
    model_clear();
    do_reset();
    rreg(4'd1, "R1");
    rreg(4'd0, "R1");

    // boot decoding
    access(1'b1, 32'h1234_5678, "R2 read");
    access(1'b0, 32'hFFFF_0000, "R2 write");
    wreg(4'd2, 32'h1234_0000);
    wreg(4'd3, 32'h0000_0001);
    access(1'b1, 32'h1234_0000, "R2 other select held off");
    wreg(4'd1, 32'h0000_0100);
    access(1'b0, 32'h0000_0000, "R2 protect ignored");

    // enable select 0
    wreg(4'd0, 32'h4000_0000);
    wreg(4'd1, 32'h0000_0001);
    access(1'b1, 32'h4000_1234, "R3 sel0");
    access(1'b1, 32'h1234_0010, "R3 sel1");
    access(1'b0, 32'h0000_0000, "R3 miss");
    tick(1'b0, 1'b1, 32'h4000_0000, 1'b0, 4'd0, 32'h0, "R7 idle");

    // discontiguous mask
    wreg(4'd4, 32'h0000_0000);
    wreg(4'd5, 32'h0008_0001);
    access(1'b1, 32'h0000_5000, "R3 low block");
    access(1'b0, 32'h0008_FFFF, "R3 high block");
    access(1'b1, 32'h0010_0000, "R3 gap");

    // protected region
    wreg(4'd6, 32'h1000_0000);
    wreg(4'd7, 32'h00FF_0101);
    access(1'b1, 32'h10AB_0000, "R6 read");
    access(1'b0, 32'h10AB_0000, "R6 write");
    tick(1'b0, 1'b0, 32'h10AB_0000, 1'b0, 4'd0, 32'h0, "R9 no start");

    // overlap
    wreg(4'd8, 32'h1000_0000);
    wreg(4'd9, 32'h0000_0001);
    access(1'b1, 32'h1000_0000, "R5 read overlap");
    access(1'b0, 32'h1000_0000, "R5 write overlap");

    // disabled select
    wreg(4'd10, 32'h2000_0000);
    wreg(4'd11, 32'h0000_0000);
    access(1'b1, 32'h2000_0000, "R4 disabled");
    wreg(4'd11, 32'h0000_0001);
    access(1'b1, 32'h2000_0000, "R4 enabled");

    // select 0 wide mask wins everything
    wreg(4'd1, 32'hFFFF_0001);
    access(1'b1, 32'h2000_0000, "R5 sel0 wins");

    // register field layout
    wreg(4'd1, 32'hFFFF_FFFF);
    rreg(4'd1, "R8 mask reserved");
    access(1'b0, 32'h2000_0000, "R6 sel0 protected");
    wreg(4'd0, 32'hFFFF_FFFF);
    rreg(4'd0, "R8 base reserved");
    wreg(4'd13, 32'hFFFF_FFFF);
    rreg(4'd13, "R8 out of range");
    rreg(4'd11, "R8 sel5 mask");

    // reset mid-run
    do_reset();
    rreg(4'd11, "R1 after reset");
    access(1'b1, 32'h2000_0000, "R2 after reset");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule